// File: doc/BRIEF.md
# Run-Length Infrared Transmit Queue

This block drives a consumer-infrared emitter from a queue of self-describing bytes. A host writes bytes through a small strobe-and-address write port. Each byte names one interval: carrier-modulated light or darkness, lasting a count of sample periods. The block stores up to 32 bytes and plays them back to back. During light intervals it produces a carrier whose period and high time the host programs as clock counts.

The host watches the queue's fill level directly. It can also enable a low-data interrupt, which fires when the fill level drops to one of four fixed levels. A clear command drops everything queued and stops playback at once. A write to a full queue is lost and leaves a sticky overflow flag that only the clear command removes.

Top module: `irtx_runlen_fifo`

## Requirements
- R1: The queue holds 32 bytes. A write to address 0 appends `wr_data` when the queue is not full. `fill_level` gives the number of stored bytes (0 to 32) and updates at the clock edge that takes the write or the byte's removal.
- R2: A write to address 0 while `fill_level` is 32 is dropped. It sets `overflow` at that edge, and `overflow` stays high until a clear command.
- R3: In a queued byte, bit 7 = 0 means a light (carrier) interval and bit 7 = 1 means a dark interval. Bits 6:0 give the length in sample periods, and 0 means 128. A sample period is TICK_DIV clocks (4 by default). A byte is taken from the queue one clock after it is written if the player is idle, or else in the cycle the current interval ends. Intervals follow one another with no gap.
- R4: Address 2 sets the carrier period count P (the period is P+1 clocks, reset 9). Address 3 sets the high count H (reset 3). During a light interval, `ir_out` is high for the first H clocks of each period, and the phase restarts at every new byte. `ir_out` is low during dark intervals and while idle. `ir_out` is registered, so it lags the interval by one clock.
- R5: `busy` is high while an interval plays. It falls once the last interval ends with the queue empty.
- R6: Bits 3:2 of the control register (address 1) select the low-data level: code 0 = 1 byte, 1 = 7, 2 = 17, 3 = 25. The reset code is 2.
- R7: Control bit 0 is the low-data enable and bit 1 is the global interrupt enable. `low_data_irq` is high one clock after a cycle in which both enables are set and the fill level is at or below the selected level. Otherwise it is low.
- R8: Writing control bit 7 = 1 empties the queue, stops playback and clears `overflow`, all at that edge. The bit is not stored. The other control bits of the same write are stored.
- R9: After reset, `fill_level` is 0 and `busy`, `ir_out`, `low_data_irq` and `overflow` are all low. Both interrupt enables are off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 data, 1 control, 2 carrier period, 3 carrier high |
| wr_data | input | 8 | Write data |
| ir_out | output | 1 | Modulated emitter drive |
| busy | output | 1 | An interval is playing |
| fill_level | output | 6 | Bytes stored in the queue |
| low_data_irq | output | 1 | Gated low-data interrupt |
| overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bound checker watches several rules on every clock. The fill level never exceeds the depth. A write to a full queue always leaves the overflow flag set, and the flag only falls on a clear. No carrier appears outside a light interval. A clear always leaves the queue empty and the player idle. The interrupt never fires while either enable is off. Other behaviour depends on exact cycle counts and can only be shown by the bench's scenarios, which compare against a queue-based model on every clock: interval lengths including the zero-means-128 case, gapless chaining, the carrier duty pattern and its phase restart, and the four threshold levels.

// File: rtl/irtx_pkg.sv
package irtx_pkg;
  localparam logic [1:0] A_DATA   = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_PERIOD = 2'd2;
  localparam logic [1:0] A_HIGH   = 2'd3;

  localparam logic [7:0] PERIOD_RST = 8'd9;
  localparam logic [7:0] HIGH_RST   = 8'd3;
  localparam logic [1:0] THR_RST    = 2'd2;

  // fixed non-linear low-data levels
  function automatic logic [5:0] low_level(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd1;
      2'd1:    return 6'd7;
      2'd2:    return 6'd17;
      default: return 6'd25;
    endcase
  endfunction
endpackage

// File: rtl/irtx_fifo.sv
module irtx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH):0]     count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      count <= count + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  assign dout  = mem[rp];
  assign full  = (count == (AW+1)'(DEPTH));
  assign empty = (count == '0);
endmodule

// File: rtl/irtx_player.sv
module irtx_player #(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       avail,
  input  logic [7:0] head,
  output logic       pop,
  output logic       active,
  output logic       pulse
);
  logic [7:0] left_q;
  logic       tick_end;
  logic       seg_end;

  assign seg_end = active && tick_end && (left_q == 8'd1);
  assign pop     = !abort && avail && (!active || seg_end);

  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int TW = $clog2(TICK_DIV);
      logic [TW-1:0] tick_q;
      assign tick_end = (tick_q == TW'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || pop || !active || tick_end) tick_q <= '0;
        else                                   tick_q <= tick_q + 1'b1;
      end
    end else begin : g_nodiv
      assign tick_end = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      pulse  <= 1'b0;
      left_q <= '0;
    end else if (abort) begin
      active <= 1'b0;
    end else if (pop) begin
      active <= 1'b1;
      pulse  <= ~head[7];
      left_q <= (head[6:0] == 7'd0) ? 8'd128 : {1'b0, head[6:0]};
    end else if (seg_end) begin
      active <= 1'b0;
    end else if (active && tick_end) begin
      left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/irtx_carrier.sv
module irtx_carrier (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       restart,
  input  logic [7:0] period,
  input  logic [7:0] high,
  output logic       out
);
  logic [7:0] ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      out <= 1'b0;
    end else begin
      out <= run && (ph < high);
      if (restart || !run)  ph <= '0;
      else if (ph == period) ph <= '0;
      else                   ph <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/irtx_runlen_fifo.sv
module irtx_runlen_fifo #(
  parameter int DEPTH    = 32,
  parameter int TICK_DIV = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [1:0]              wr_addr,
  input  logic [7:0]              wr_data,
  output logic                    ir_out,
  output logic                    busy,
  output logic [$clog2(DEPTH):0]  fill_level,
  output logic                    low_data_irq,
  output logic                    overflow
);
  import irtx_pkg::*;
  localparam int CW = $clog2(DEPTH) + 1;

  logic       en_low_q, en_glb_q;
  logic [1:0] thr_q;
  logic [7:0] period_q, high_q;
  logic       clr, push, pop, full, empty;
  logic [7:0] head;
  logic       play_pulse;

  assign clr  = wr_en && (wr_addr == A_CTRL) && wr_data[7];
  assign push = wr_en && (wr_addr == A_DATA) && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_low_q <= 1'b0;
      en_glb_q <= 1'b0;
      thr_q    <= THR_RST;
      period_q <= PERIOD_RST;
      high_q   <= HIGH_RST;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          en_low_q <= wr_data[0];
          en_glb_q <= wr_data[1];
          thr_q    <= wr_data[3:2];
        end
        A_PERIOD: period_q <= wr_data;
        A_HIGH:   high_q   <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) overflow <= 1'b0;
    else if (wr_en && (wr_addr == A_DATA) && full) overflow <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) low_data_irq <= 1'b0;
    else     low_data_irq <= en_low_q && en_glb_q &&
                             (fill_level <= CW'(low_level(thr_q)));
  end

  irtx_fifo #(.DEPTH(DEPTH), .W(8)) u_fifo (
    .clk(clk), .rst(rst), .clr(clr), .push(push), .din(wr_data),
    .pop(pop), .dout(head), .count(fill_level), .full(full), .empty(empty)
  );

  irtx_player #(.TICK_DIV(TICK_DIV)) u_player (
    .clk(clk), .rst(rst), .abort(clr), .avail(!empty), .head(head),
    .pop(pop), .active(busy), .pulse(play_pulse)
  );

  irtx_carrier u_carrier (
    .clk(clk), .rst(rst), .run(busy && play_pulse), .restart(pop),
    .period(period_q), .high(high_q), .out(ir_out)
  );
endmodule

// File: rtl/irtx_runlen_fifo_chk.sv
module irtx_runlen_fifo_chk #(
  parameter int DEPTH = 32
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   wr_en,
  input logic [1:0]             wr_addr,
  input logic [7:0]             wr_data,
  input logic                   ir_out,
  input logic                   busy,
  input logic [$clog2(DEPTH):0] fill_level,
  input logic                   low_data_irq,
  input logic                   overflow,
  input logic                   en_low,
  input logic                   en_glb,
  input logic                   play_pulse
);
  localparam int CW = $clog2(DEPTH) + 1;
  logic clr_cmd;
  assign clr_cmd = wr_en && (wr_addr == 2'd1) && wr_data[7];

  p_fill_bound_r1: assert property (@(posedge clk) disable iff (rst)
    fill_level <= CW'(DEPTH));

  p_overflow_set_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == 2'd0 && fill_level == CW'(DEPTH)) |=> overflow);

  p_overflow_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (overflow && !clr_cmd) |=> overflow);

  p_dark_outside_light_r4: assert property (@(posedge clk) disable iff (rst)
    !(busy && play_pulse) |=> !ir_out);

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !(en_low && en_glb) |=> !low_data_irq);

  p_clear_empties_r8: assert property (@(posedge clk) disable iff (rst)
    clr_cmd |=> (fill_level == '0 && !busy && !overflow));
endmodule

bind irtx_runlen_fifo irtx_runlen_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .ir_out(ir_out), .busy(busy), .fill_level(fill_level),
  .low_data_irq(low_data_irq), .overflow(overflow),
  .en_low(en_low_q), .en_glb(en_glb_q), .play_pulse(play_pulse)
);

// File: tb/irtx_runlen_fifo_test.sv
module irtx_runlen_fifo_test;
  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       ir_out, busy, low_data_irq, overflow;
  logic [5:0] fill_level;

  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  irtx_runlen_fifo uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ir_out(ir_out), .busy(busy), .fill_level(fill_level),
    .low_data_irq(low_data_irq), .overflow(overflow)
  );

  // behavioural reference model, stepped once per clock edge
  logic [7:0] q[$];
  bit m_act, m_pul, m_ir, m_irq, m_ovf, m_enl, m_eng;
  int m_left, m_ph, m_thr, m_P, m_H;
  bit t_clr, t_full, t_ld, t_oact, t_opul, t_ir, t_irq;
  logic [7:0] t_b;

  function automatic int lvl(input int code);
    case (code)
      0: return 1;
      1: return 7;
      2: return 17;
      default: return 25;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      m_act = 0; m_pul = 0; m_ir = 0; m_irq = 0; m_ovf = 0;
      m_enl = 0; m_eng = 0; m_left = 0; m_ph = 0;
      m_thr = 2; m_P = 9; m_H = 3;
    end else begin
      t_clr  = wr_en && wr_addr == 2'd1 && wr_data[7];
      t_full = (q.size() == 32);
      t_ir   = m_act && m_pul && (m_ph < m_H);
      t_irq  = m_enl && m_eng && (q.size() <= lvl(m_thr));
      t_oact = m_act; t_opul = m_pul; t_ld = 0;
      if (t_clr) begin
        m_act = 0;
        q.delete();
        m_ovf = 0;
      end else if (!m_act || m_left == 1) begin
        if (q.size() > 0) begin
          t_b = q.pop_front();
          t_ld = 1; m_act = 1; m_pul = !t_b[7];
          m_left = ((t_b[6:0] == 0) ? 128 : int'(t_b[6:0])) * DIV;
        end else m_act = 0;
      end else m_left--;
      if (t_ld || !(t_oact && t_opul)) m_ph = 0;
      else m_ph = (m_ph == m_P) ? 0 : m_ph + 1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: if (!t_clr) begin
                  if (t_full) m_ovf = 1; else q.push_back(wr_data);
                end
          2'd1: begin m_enl = wr_data[0]; m_eng = wr_data[1]; m_thr = int'(wr_data[3:2]); end
          2'd2: m_P = int'(wr_data);
          default: m_H = int'(wr_data);
        endcase
      end
      m_ir = t_ir; m_irq = t_irq;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model
  always @(negedge clk) begin
    if (!rst) begin
      chk(fill_level == 6'(q.size()), "R1 fill_level", fill_level, q.size());
      chk(overflow == m_ovf, "R2 overflow", overflow, m_ovf);
      chk(ir_out == m_ir, "R4 ir_out", ir_out, m_ir);
      chk(busy == m_act, "R5 busy", busy, m_act);
      chk(low_data_irq == m_irq, "R7 low_data_irq", low_data_irq, m_irq);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // counts busy cycles of the next playback run
  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < 8 && !busy; i++) @(negedge clk);
    for (int i = 0; i < 4000 && busy; i++) begin n++; @(negedge clk); end
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int n, hi;
    repeat (4) @(negedge clk);
    // R9 reset state
    chk(fill_level == 0, "R9 fill", fill_level, 0);
    chk(!busy && !ir_out, "R9 busy/ir", {busy, ir_out}, 0);
    chk(!low_data_irq && !overflow, "R9 irq/ovf", {low_data_irq, overflow}, 0);
    rst = 1'b0;
    idle(3);

    // R3 single light byte of 5 periods, zero length = 128 periods
    wr(2'd0, 8'h05);
    busy_len(n);
    chk(n == 5 * DIV, "R3 len5", n, 5 * DIV);
    wr(2'd0, 8'h80);
    busy_len(n);
    chk(n == 128 * DIV, "R3 len0=128", n, 128 * DIV);
    // R3 back-to-back chaining, no gap
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 8'h02;
    @(negedge clk); wr_data = 8'h83;
    @(negedge clk); wr_en = 0;
    busy_len(n);
    chk(n == 5 * DIV, "R3 chained", n, 5 * DIV);

    // R4 duty: period 4, high 2, light byte of 2 periods -> 4 high clocks
    wr(2'd2, 8'd3);
    wr(2'd3, 8'd2);
    wr(2'd0, 8'h02);
    hi = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (ir_out) hi++; end
    chk(hi == 4, "R4 high clocks", hi, 4);

    // R6/R7 thresholds while a long dark interval holds the player
    wr(2'd1, 8'h0B);
    wr(2'd0, 8'h80);
    for (int i = 0; i < 17; i++) wr(2'd0, 8'h81);
    idle(2);
    chk(low_data_irq == 1, "R6 code2 at 17", low_data_irq, 1);
    wr(2'd0, 8'h81);
    idle(2);
    chk(low_data_irq == 0, "R6 code2 at 18", low_data_irq, 0);
    wr(2'd1, 8'h0F);
    idle(2);
    chk(low_data_irq == 1, "R6 code3 at 18", low_data_irq, 1);
    wr(2'd1, 8'h07);
    idle(2);
    chk(low_data_irq == 0, "R6 code1 at 18", low_data_irq, 0);
    wr(2'd1, 8'h0D);
    idle(2);
    chk(low_data_irq == 0, "R7 global off", low_data_irq, 0);

    // R2 overflow
    for (int i = 0; i < 16; i++) wr(2'd0, 8'h81);
    chk(fill_level == 32, "R2 full", fill_level, 32);
    chk(overflow == 1, "R2 sticky set", overflow, 1);
    idle(5);
    chk(overflow == 1, "R2 sticky held", overflow, 1);

    // R8 clear with code 0 and both enables
    wr(2'd1, 8'h83);
    chk(fill_level == 0 && !busy, "R8 emptied", {fill_level, busy}, 0);
    chk(overflow == 0, "R8 ovf cleared", overflow, 0);
    idle(2);
    chk(low_data_irq == 1, "R6 code0 at 0", low_data_irq, 1);

    // carrier patterns compared by the model
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h03); wr(2'd0, 8'h02); wr(2'd0, 8'h04);
    wr(2'd2, 8'd0); wr(2'd3, 8'd1);
    wr(2'd0, 8'h03);
    idle(60);
    wr(2'd3, 8'd0);
    wr(2'd0, 8'h02);
    wr(2'd2, 8'd6); wr(2'd3, 8'd200);
    wr(2'd0, 8'h01); wr(2'd0, 8'h00);
    busy_len(n);
    idle(3);
    chk(!busy && fill_level == 0, "R5 idle after drain", busy, 0);
    chk(!ir_out, "R4 dark when idle", ir_out, 0);

    summary();
    $finish;
  end
endmodule